// File: doc/BRIEF.md
# Bus Matrix Access Permission Filter

This block sits between the masters of an AHB-Lite style bus matrix and the slave-select logic. Every master has its own guard. The guard decodes the upper address bits of each address phase to pick one of five memory slaves: two SRAM regions, two non-volatile memory regions and a DDR bridge. It then checks the transfer against a read-deny bit and a write-deny bit held for that master and slave. A permitted transfer reaches the slave side unchanged. A denied transfer never reaches a slave, gets the two-cycle AHB error response, and sets a sticky error flag for that master.

The deny vector is a static configuration input. The block registers it internally, and that register resets to "everything allowed". The last master index is a DDR fabric path that is not part of the main matrix. For this path only the DDR permission bits are enforced, and its other traffic passes straight through. Software clears the error flags with a write-one-to-clear strobe.

Top module: `bm_access_filter`

## Requirements
- R1: The internal permission copy resets to allow-all. A transfer presented in the cycle that reset is released is forwarded even if every deny input is 1. A change on the deny inputs takes effect one clock later.
- R2: The slave is chosen from haddr[31:28]. Code 0x2 selects SRAM A (s_hsel bit 0), 0x3 selects SRAM B (bit 1), 0x6 selects NVM A (bit 2), 0x7 selects NVM B (bit 3) and 0xA selects the DDR bridge (bit 4). At most one s_hsel bit is set per master.
- R3: deny_rd[m][s]=1 blocks reads of slave s by master m. deny_wr[m][s]=1 blocks writes. Each bit affects only its own direction.
- R4: A permitted transfer drives s_hsel, s_htrans, s_haddr and s_hwrite from the master's signals. In its data phase, s_hready, s_hresp and s_hrdata are returned to the master, including slave wait states.
- R5: A blocked transfer gives s_hsel=0, s_htrans=IDLE (2'b00) and s_hwrite=0.
- R6: A blocked or unmapped transfer gets a two-cycle data phase. In the first cycle m_hresp=1 and m_hready=0. In the second cycle m_hresp=1 and m_hready=1. m_hrdata is 0xDEADBEEF in both cycles.
- R7: An address whose code matches no region gets the R6 response and does not set the error flag.
- R8: err_flag[m] is set at the clock edge where a permission-blocked address phase is accepted. It stays set until err_clr[m] is high at an edge. If a new block and a clear occur at the same edge, the flag is set.
- R9: For the fabric master (highest index), only the DDR bit of each direction is enforced. Its transfers to other regions are forwarded whatever its deny bits hold.
- R10: An address phase is taken only when m_htrans[1]=1 and m_hready=1. During the first error cycle, nothing is forwarded to the slaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| deny_rd | input | NUM_MASTERS x 5 | Read-deny bit per master and slave |
| deny_wr | input | NUM_MASTERS x 5 | Write-deny bit per master and slave |
| err_clr | input | NUM_MASTERS | Write-one-to-clear strobe for the error flags |
| m_htrans | input | NUM_MASTERS x 2 | Master transfer type |
| m_haddr | input | NUM_MASTERS x ADDR_W | Master address |
| m_hwrite | input | NUM_MASTERS | Master write direction |
| s_hrdata | input | NUM_MASTERS x DATA_W | Read data returned from the selected slave |
| s_hready | input | NUM_MASTERS | Ready returned from the selected slave |
| s_hresp | input | NUM_MASTERS | Response returned from the selected slave |
| s_hsel | output | NUM_MASTERS x 5 | Forwarded one-hot slave select |
| s_htrans | output | NUM_MASTERS x 2 | Forwarded transfer type |
| s_haddr | output | NUM_MASTERS x ADDR_W | Forwarded address |
| s_hwrite | output | NUM_MASTERS | Forwarded write direction |
| m_hrdata | output | NUM_MASTERS x DATA_W | Read data to the master |
| m_hready | output | NUM_MASTERS | Ready to the master |
| m_hresp | output | NUM_MASTERS | Response to the master |
| err_flag | output | NUM_MASTERS | Sticky permission-violation flag |

## Verification
The assertions check several rules on every cycle. They check that the select stays one-hot. They check that a denied address phase is followed by the stalled error cycle carrying the filler word, and that the stalled cycle is followed by the completing one. They also cover flag stickiness, the priority of a new block over a clear, and the reset value of the permission copy. Other behaviour depends on particular address and permission combinations, so only the bench scenarios can show it. That covers the region map, the independence of the read and write bits, the fabric master's DDR-only gating and the one-cycle delay of new deny settings. The bench sweeps every region code, both directions and several deny patterns for every master.

// File: rtl/bmaf_pkg.sv
// Package: constants and types shared by the access filter.
// Assumes a fixed five-slave region map, decoded from the top address nibble.
package bmaf_pkg;

    localparam int NUM_SLAVES = 5;
    localparam int SLV_SRAM_A = 0;
    localparam int SLV_SRAM_B = 1;
    localparam int SLV_NVM_A  = 2;
    localparam int SLV_NVM_B  = 3;
    localparam int SLV_DDR    = 4;

    localparam int REGION_W = 4;

    // Region code of each slave, indexed by slave number.
    localparam logic [REGION_W-1:0] REGION_CODE [NUM_SLAVES] =
        '{4'h2, 4'h3, 4'h6, 4'h7, 4'hA};

    localparam logic [1:0] HTRANS_IDLE = 2'b00;

    typedef enum logic [1:0] {
        DP_IDLE = 2'd0,
        DP_FWD  = 2'd1,
        DP_ERR1 = 2'd2,
        DP_ERR2 = 2'd3
    } dphase_t;

endpackage

// File: rtl/bmaf_region_decode.sv
// Region decoder: turns the top address field into a one-hot slave select.
// Assumes the region codes in the package are distinct.
module bmaf_region_decode
    import bmaf_pkg::*;
(
    input  logic [REGION_W-1:0]   code,
    output logic [NUM_SLAVES-1:0] sel,
    output logic                  hit
);

    // One comparator per slave region.
    for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_cmp
        assign sel[s] = (code == REGION_CODE[s]);
    end

    // A transfer is mapped when any region matches.
    assign hit = |sel;

endmodule

// File: rtl/bmaf_perm_shadow.sv
// Permission shadow: a registered copy of the static deny vectors.
// Assumes the deny inputs are quasi-static. Reset value is allow-all.
module bmaf_perm_shadow
    import bmaf_pkg::*;
#(
    parameter int NUM_MASTERS = 11
)(
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_MASTERS-1:0][NUM_SLAVES-1:0] deny_rd_i,
    input  logic [NUM_MASTERS-1:0][NUM_SLAVES-1:0] deny_wr_i,
    output logic [NUM_MASTERS-1:0][NUM_SLAVES-1:0] deny_rd_q,
    output logic [NUM_MASTERS-1:0][NUM_SLAVES-1:0] deny_wr_q
);

    // Capture the deny vectors each cycle; clear them to allow-all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deny_rd_q <= '0;
            deny_wr_q <= '0;
        end else begin
            deny_rd_q <= deny_rd_i;
            deny_wr_q <= deny_wr_i;
        end
    end

    // R1: the first cycle after reset sees allow-all.
    a_r1_reset_allow: assert property (@(posedge clk)
        $fell(!rst_n) |-> (deny_rd_q == '0 && deny_wr_q == '0));

endmodule

// File: rtl/bmaf_port_guard.sv
// Port guard: permission check, forwarding gate, error data phase and
// sticky flag for one master.
// Assumes AHB-Lite timing: an address phase is taken when htrans[1] and
// hready are both high, and its data phase follows on the next cycle.
module bmaf_port_guard
    import bmaf_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              DATA_W    = 32,
    parameter bit              DDR_ONLY  = 1'b0,
    parameter logic [DATA_W-1:0] FILL_WORD = '0
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SLAVES-1:0] deny_rd,
    input  logic [NUM_SLAVES-1:0] deny_wr,
    input  logic                  err_clr,
    input  logic [1:0]            m_htrans,
    input  logic [ADDR_W-1:0]     m_haddr,
    input  logic                  m_hwrite,
    input  logic [DATA_W-1:0]     s_hrdata,
    input  logic                  s_hready,
    input  logic                  s_hresp,
    output logic [NUM_SLAVES-1:0] s_hsel,
    output logic [1:0]            s_htrans,
    output logic [ADDR_W-1:0]     s_haddr,
    output logic                  s_hwrite,
    output logic [DATA_W-1:0]     m_hrdata,
    output logic                  m_hready,
    output logic                  m_hresp,
    output logic                  err_flag
);

    localparam int REGION_LO = ADDR_W - REGION_W;
    localparam logic [NUM_SLAVES-1:0] GUARD_MASK =
        DDR_ONLY ? NUM_SLAVES'(1 << SLV_DDR) : {NUM_SLAVES{1'b1}};

    logic [NUM_SLAVES-1:0] sel;
    logic                  hit;
    logic                  perm_ok;
    logic                  active;
    logic                  gate_open;
    logic                  fwd;
    logic                  accept;
    logic                  deny_hit;
    dphase_t               dp_q, dp_d;

    bmaf_region_decode u_dec (
        .code (m_haddr[ADDR_W-1:REGION_LO]),
        .sel  (sel),
        .hit  (hit)
    );

    // Look up the deny bit for the decoded slave and this direction.
    always_comb begin
        if (m_hwrite) perm_ok = ~|(sel & deny_wr & GUARD_MASK);
        else          perm_ok = ~|(sel & deny_rd & GUARD_MASK);
    end

    assign active    = m_htrans[1];
    assign gate_open = (dp_q != DP_ERR1);
    assign fwd       = active & hit & perm_ok & gate_open;
    assign accept    = active & m_hready;
    assign deny_hit  = accept & hit & ~perm_ok;

    // Drive the slave-side address phase only for a permitted transfer.
    always_comb begin
        s_haddr  = m_haddr;
        s_hsel   = fwd ? sel : '0;
        s_htrans = fwd ? m_htrans : HTRANS_IDLE;
        s_hwrite = fwd & m_hwrite;
    end

    // Choose the next data phase state from the current state and acceptance.
    always_comb begin
        if (dp_q == DP_ERR1)                  dp_d = DP_ERR2;
        else if (dp_q == DP_FWD && !s_hready) dp_d = DP_FWD;
        else if (accept)                      dp_d = fwd ? DP_FWD : DP_ERR1;
        else                                  dp_d = DP_IDLE;
    end

    // Hold the data phase state.
    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= DP_IDLE;
        else        dp_q <= dp_d;
    end

    // Build the response to the master for the current data phase.
    always_comb begin
        case (dp_q)
            DP_FWD: begin
                m_hready = s_hready;
                m_hresp  = s_hresp;
                m_hrdata = s_hrdata;
            end
            DP_ERR1: begin
                m_hready = 1'b0;
                m_hresp  = 1'b1;
                m_hrdata = FILL_WORD;
            end
            DP_ERR2: begin
                m_hready = 1'b1;
                m_hresp  = 1'b1;
                m_hrdata = FILL_WORD;
            end
            default: begin
                m_hready = 1'b1;
                m_hresp  = 1'b0;
                m_hrdata = '0;
            end
        endcase
    end

    // Sticky violation flag; a new block wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_flag <= 1'b0;
        else if (deny_hit) err_flag <= 1'b1;
        else if (err_clr)  err_flag <= 1'b0;
    end

    // R2: the forwarded select is never more than one slave.
    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_hsel));

    // R6: a refused address phase leads to the stalled error cycle with filler.
    a_r6_err_first: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !fwd) |=> (m_hresp && !m_hready && m_hrdata == FILL_WORD));

    // R6: the stalled error cycle is followed by the completing error cycle.
    a_r6_err_second: assert property (@(posedge clk) disable iff (!rst_n)
        (m_hresp && !m_hready && dp_q == DP_ERR1) |=> (m_hresp && m_hready));

    // R10: nothing reaches a slave while the master is stalled by an error.
    a_r10_no_fwd_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_q == DP_ERR1) |-> (s_hsel == '0 && !s_hwrite));

    // R8: the flag holds until cleared.
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    // R8: a block in the same cycle as a clear leaves the flag set.
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (deny_hit && err_clr) |=> err_flag);

endmodule

// File: rtl/bm_access_filter.sv
// Top: replicates one guard per master behind a shared permission shadow.
// Assumes the highest master index is the DDR fabric path, which is gated
// only for the DDR slave.
module bm_access_filter
    import bmaf_pkg::*;
#(
    parameter int NUM_MASTERS = 11,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32
)(
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_MASTERS-1:0][NUM_SLAVES-1:0] deny_rd,
    input  logic [NUM_MASTERS-1:0][NUM_SLAVES-1:0] deny_wr,
    input  logic [NUM_MASTERS-1:0]                 err_clr,
    input  logic [NUM_MASTERS-1:0][1:0]            m_htrans,
    input  logic [NUM_MASTERS-1:0][ADDR_W-1:0]     m_haddr,
    input  logic [NUM_MASTERS-1:0]                 m_hwrite,
    input  logic [NUM_MASTERS-1:0][DATA_W-1:0]     s_hrdata,
    input  logic [NUM_MASTERS-1:0]                 s_hready,
    input  logic [NUM_MASTERS-1:0]                 s_hresp,
    output logic [NUM_MASTERS-1:0][NUM_SLAVES-1:0] s_hsel,
    output logic [NUM_MASTERS-1:0][1:0]            s_htrans,
    output logic [NUM_MASTERS-1:0][ADDR_W-1:0]     s_haddr,
    output logic [NUM_MASTERS-1:0]                 s_hwrite,
    output logic [NUM_MASTERS-1:0][DATA_W-1:0]     m_hrdata,
    output logic [NUM_MASTERS-1:0]                 m_hready,
    output logic [NUM_MASTERS-1:0]                 m_hresp,
    output logic [NUM_MASTERS-1:0]                 err_flag
);

    localparam int FABRIC_MASTER = NUM_MASTERS - 1;
    localparam logic [DATA_W-1:0] FILL_WORD = DATA_W'(32'hDEAD_BEEF);

    logic [NUM_MASTERS-1:0][NUM_SLAVES-1:0] deny_rd_q;
    logic [NUM_MASTERS-1:0][NUM_SLAVES-1:0] deny_wr_q;

    bmaf_perm_shadow #(.NUM_MASTERS(NUM_MASTERS)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .deny_rd_i (deny_rd),
        .deny_wr_i (deny_wr),
        .deny_rd_q (deny_rd_q),
        .deny_wr_q (deny_wr_q)
    );

    // One guard per master; the fabric path gets the DDR-only variant.
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_guard
        bmaf_port_guard #(
            .ADDR_W    (ADDR_W),
            .DATA_W    (DATA_W),
            .DDR_ONLY  (m == FABRIC_MASTER),
            .FILL_WORD (FILL_WORD)
        ) u_guard (
            .clk      (clk),
            .rst_n    (rst_n),
            .deny_rd  (deny_rd_q[m]),
            .deny_wr  (deny_wr_q[m]),
            .err_clr  (err_clr[m]),
            .m_htrans (m_htrans[m]),
            .m_haddr  (m_haddr[m]),
            .m_hwrite (m_hwrite[m]),
            .s_hrdata (s_hrdata[m]),
            .s_hready (s_hready[m]),
            .s_hresp  (s_hresp[m]),
            .s_hsel   (s_hsel[m]),
            .s_htrans (s_htrans[m]),
            .s_haddr  (s_haddr[m]),
            .s_hwrite (s_hwrite[m]),
            .m_hrdata (m_hrdata[m]),
            .m_hready (m_hready[m]),
            .m_hresp  (m_hresp[m]),
            .err_flag (err_flag[m])
        );
    end

endmodule

// File: tb/bm_access_filter_test.sv
`timescale 1ns/1ps
module bm_access_filter_test;
    localparam int NM  = 11;
    localparam int NS  = 5;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int FAB = NM - 1;
    localparam logic [31:0] FILL = 32'hDEAD_BEEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NM-1:0][NS-1:0] deny_rd = '0;
    logic [NM-1:0][NS-1:0] deny_wr = '0;
    logic [NM-1:0]         err_clr = '0;
    logic [NM-1:0][1:0]    m_htrans = '0;
    logic [NM-1:0][AW-1:0] m_haddr = '0;
    logic [NM-1:0]         m_hwrite = '0;
    logic [NM-1:0][DW-1:0] s_hrdata = '0;
    logic [NM-1:0]         s_hready = '1;
    logic [NM-1:0]         s_hresp = '0;
    logic [NM-1:0][NS-1:0] s_hsel;
    logic [NM-1:0][1:0]    s_htrans;
    logic [NM-1:0][AW-1:0] s_haddr;
    logic [NM-1:0]         s_hwrite;
    logic [NM-1:0][DW-1:0] m_hrdata;
    logic [NM-1:0]         m_hready;
    logic [NM-1:0]         m_hresp;
    logic [NM-1:0]         err_flag;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    bm_access_filter #(.NUM_MASTERS(NM), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .deny_rd(deny_rd), .deny_wr(deny_wr),
        .err_clr(err_clr), .m_htrans(m_htrans), .m_haddr(m_haddr),
        .m_hwrite(m_hwrite), .s_hrdata(s_hrdata), .s_hready(s_hready),
        .s_hresp(s_hresp), .s_hsel(s_hsel), .s_htrans(s_htrans),
        .s_haddr(s_haddr), .s_hwrite(s_hwrite), .m_hrdata(m_hrdata),
        .m_hready(m_hready), .m_hresp(m_hresp), .err_flag(err_flag)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Region map from R2: returns slave index or -1 when unmapped.
    function automatic int exp_slave(input logic [3:0] code);
        case (code)
            4'h2: return 0;
            4'h3: return 1;
            4'h6: return 2;
            4'h7: return 3;
            4'hA: return 4;
            default: return -1;
        endcase
    endfunction

    // One full transfer on master m; caller is at a negedge.
    task automatic xfer(input int m, input logic [3:0] code, input bit wr,
                        input logic [NS-1:0] rmask, input logic [NS-1:0] wmask);
        logic [31:0] addr;
        int          s;
        bit          blocked;
        bit          fwd;
        logic [NS-1:0] exp_sel;
        addr = {code, 20'h0, 8'(m)};
        s = exp_slave(code);
        blocked = 1'b0;
        if (s >= 0) begin
            blocked = wr ? wmask[s] : rmask[s];
            if (m == FAB && s != 4) blocked = 1'b0;   // R9
        end
        fwd = (s >= 0) && !blocked;
        exp_sel = fwd ? NS'(1 << s) : '0;
        m_htrans[m] = 2'b10;
        m_haddr[m]  = addr;
        m_hwrite[m] = wr;
        s_hrdata[m] = ~addr;
        #1;
        chk(s_hsel[m] == exp_sel, fwd ? "R4 sel" : "R5 sel", 32'(s_hsel[m]), 32'(exp_sel));
        chk(s_hwrite[m] == (fwd & wr), "R5 hwrite", 32'(s_hwrite[m]), 32'(fwd & wr));
        chk(s_htrans[m] == (fwd ? 2'b10 : 2'b00), "R5 htrans", 32'(s_htrans[m]), fwd ? 32'd2 : 32'd0);
        if (fwd) chk(s_haddr[m] == addr, "R4 haddr", s_haddr[m], addr);
        @(posedge clk); @(negedge clk);
        m_htrans[m] = 2'b00;
        #1;
        if (fwd) begin
            chk(m_hready[m] && !m_hresp[m], "R4 resp", {m_hready[m], m_hresp[m]}, 32'h2);
            chk(m_hrdata[m] == ~addr, "R4 rdata", m_hrdata[m], ~addr);
        end else begin
            chk(!m_hready[m] && m_hresp[m], "R6 first", {m_hready[m], m_hresp[m]}, 32'h1);
            chk(m_hrdata[m] == FILL, "R6 fill", m_hrdata[m], FILL);
        end
        chk(err_flag[m] == ((s >= 0) && blocked), (s < 0) ? "R7 flag" : "R8 flag",
            32'(err_flag[m]), 32'((s >= 0) && blocked));
        if (!fwd) begin
            @(negedge clk); #1;
            chk(m_hready[m] && m_hresp[m], "R6 second", {m_hready[m], m_hresp[m]}, 32'h3);
            chk(m_hrdata[m] == FILL, "R6 fill2", m_hrdata[m], FILL);
        end
        err_clr[m] = 1'b1;
        @(negedge clk);
        err_clr[m] = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [NS-1:0] rm [4];
        logic [NS-1:0] wm [4];
        rm = '{5'h00, 5'h1F, 5'h00, 5'h0A};
        wm = '{5'h00, 5'h00, 5'h1F, 5'h15};

        // Reset state, with every deny input set (R1).
        deny_rd = '1;
        deny_wr = '1;
        repeat (3) @(negedge clk);
        #1;
        chk(m_hready == '1, "R1 reset hready", 32'(m_hready), 32'h7FF);
        chk(m_hresp == '0 && err_flag == '0, "R1 reset resp/flag",
            32'({m_hresp, err_flag}), 32'h0);
        chk(s_hsel == '0, "R1 reset sel", 32'(s_hsel[0]), 32'h0);

        // R1: first transfer after release still sees allow-all.
        @(negedge clk);
        rst_n = 1'b1;
        m_htrans[0] = 2'b10; m_haddr[0] = 32'h2000_0000; m_hwrite[0] = 1'b0;
        #1;
        chk(s_hsel[0] == 5'b00001, "R1 allow after reset", 32'(s_hsel[0]), 32'h1);
        @(negedge clk);
        m_htrans[0] = 2'b00;
        @(negedge clk);
        // R1: the registered deny bits now block the same read.
        m_htrans[0] = 2'b10;
        #1;
        chk(s_hsel[0] == 5'b0, "R1 deny after load", 32'(s_hsel[0]), 32'h0);
        @(negedge clk);
        m_htrans[0] = 2'b00;
        @(negedge clk);
        err_clr = '1;
        @(negedge clk);
        err_clr = '0;

        // Sweep over masters, region codes, directions and deny patterns (R2 R3 R5 R6 R7 R9).
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < NM; m++) begin
                deny_rd[m] = rm[p];
                deny_wr[m] = wm[p];
            end
            @(negedge clk); @(negedge clk);
            for (int m = 0; m < NM; m++)
                for (int c = 0; c < 16; c++)
                    for (int w = 0; w < 2; w++)
                        xfer(m, 4'(c), w[0], rm[p], wm[p]);
        end

        // R4: a slave wait state reaches the master.
        deny_rd = '0; deny_wr = '0;
        @(negedge clk); @(negedge clk);
        m_htrans[2] = 2'b10; m_haddr[2] = 32'h6000_0040; m_hwrite[2] = 1'b0;
        s_hrdata[2] = 32'h1234_5678; s_hready[2] = 1'b0;
        @(negedge clk);
        m_htrans[2] = 2'b00;
        #1;
        chk(!m_hready[2], "R4 wait state", 32'(m_hready[2]), 32'h0);
        @(negedge clk);
        s_hready[2] = 1'b1;
        #1;
        chk(m_hready[2] && m_hrdata[2] == 32'h1234_5678, "R4 wait done",
            m_hrdata[2], 32'h1234_5678);
        @(negedge clk);

        // R10 and R3: blocked read, then a permitted write offered in the stall cycle.
        deny_rd[3] = '1; deny_wr[3] = '0;
        @(negedge clk); @(negedge clk);
        m_htrans[3] = 2'b10; m_haddr[3] = 32'h3000_0000; m_hwrite[3] = 1'b0;
        @(negedge clk);
        m_hwrite[3] = 1'b1;
        #1;
        chk(s_hsel[3] == '0 && !m_hready[3], "R10 stall no fwd", 32'(s_hsel[3]), 32'h0);
        @(negedge clk); #1;
        chk(s_hsel[3] == 5'b00010 && s_hwrite[3], "R10 fwd after stall", 32'(s_hsel[3]), 32'h2);
        @(negedge clk);
        m_htrans[3] = 2'b00;
        #1;
        chk(m_hready[3] && !m_hresp[3], "R3 write allowed", {m_hready[3], m_hresp[3]}, 32'h2);
        @(negedge clk);

        // R8: a block coinciding with a clear sets the flag; it then holds until cleared.
        err_clr = '1;
        @(negedge clk);
        m_htrans[3] = 2'b10; m_haddr[3] = 32'h7000_0000; m_hwrite[3] = 1'b0;
        @(negedge clk);
        m_htrans[3] = 2'b00; err_clr = '0;
        #1;
        chk(err_flag[3], "R8 set beats clear", 32'(err_flag[3]), 32'h1);
        repeat (4) @(negedge clk);
        #1;
        chk(err_flag[3], "R8 sticky", 32'(err_flag[3]), 32'h1);
        err_clr[3] = 1'b1;
        @(negedge clk);
        err_clr[3] = 1'b0;
        #1;
        chk(!err_flag[3], "R8 cleared", 32'(err_flag[3]), 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule